// File: doc/BRIEF.md
# Dual Masked I2C Target Address Matcher

This block decides whether the address phase of an I2C transfer selects this target. A byte-level receiver in front of it hands over each received byte with a valid strobe. The strobe comes with a marker for the first byte after a START and a pulse that reports any START or repeated START seen on the bus. The matcher compares the address against a configurable number of address slots (two by default). Each slot holds a 10-bit address and a 10-bit don't-care mask. The block can work in 7-bit mode or in the two-byte 10-bit mode, and it can also accept the general-call address.

The decision is registered. One cycle after the strobe of the deciding byte, the block raises `match`. In the same cycle it raises `ack_req` when the acknowledge enable is set and `read_req` when the transfer direction is read. Each slot has a sticky status bit that records a hit by that slot, and software clears the bit by writing a one to it. In 10-bit mode, the first byte only arms the slots whose upper address bits agree. The second byte then completes the match.

Top module: `i2c_dual_addr_match`

## Requirements
- R1: After reset `match`, `ack_req`, `read_req` and every `hit_sts` bit are 0.
- R2: In 7-bit mode, a first byte whose bits [7:1] equal a slot's address bits [6:0] makes that slot hit. Bits where the slot mask is 1 are ignored in the compare. `match` is 1 in the cycle after the strobe, and byte bit 0 is the direction bit (1 = read).
- R3: In 7-bit mode, a first byte with bits [7:1] all zero never makes a slot hit. The byte 0x00 gives `match` without setting any status bit, but only when `cfg_gc_en` is 1.
- R4: In 10-bit mode, a first byte of the form 11110AAX arms each slot whose address bits [9:8] agree with AA, with masking applied. The first byte never raises `match`. It raises `ack_req` when at least one slot is armed and `cfg_ack_en` is 1.
- R5: In 10-bit mode, the next non-first byte is compared with address bits [7:0] of the armed slots, with masking applied. A hit on this byte raises `match`.
- R6: A `start_det` pulse disarms all slots. A byte strobed in the same cycle as `start_det` is ignored.
- R7: `hit_sts[i]` becomes 1 in the same cycle as `match` when slot i hit, and both bits become 1 when both slots hit. A `sts_clr[i]` pulse clears the bit, but a new hit in the same cycle wins over the clear.
- R8: `read_req` is 1 together with a slot match whose direction bit is 1. In 10-bit mode the direction bit is bit 0 of the first byte.
- R9: `ack_req` is 0 whenever `cfg_ack_en` was 0 at the deciding byte. The match itself still occurs.
- R10: A non-first byte that arrives while no slot is armed is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det | input | 1 | START or repeated START seen on the bus |
| byte_vld | input | 1 | Received byte strobe |
| byte_first | input | 1 | Strobed byte is the first after a START |
| byte_data | input | 8 | Received byte |
| cfg_ten_bit | input | 1 | 1 = 10-bit addressing |
| cfg_gc_en | input | 1 | Accept general call |
| cfg_ack_en | input | 1 | Acknowledge matched addresses |
| slot_addr | input | 10*SLOTS | Slot addresses, slot i at bits [10i+9:10i] |
| slot_mask | input | 10*SLOTS | Slot don't-care masks, same layout |
| sts_clr | input | SLOTS | Write-one-to-clear pulses for status |
| match | output | 1 | Address selected this target |
| ack_req | output | 1 | Request ACK for the byte just received |
| read_req | output | 1 | Matched transfer is a read |
| hit_sts | output | SLOTS | Sticky per-slot hit status |

## Verification
The checker assumes that `byte_vld` is a single-cycle strobe. It also assumes that the configuration inputs and slot registers stay still while an address phase is in progress, and that slot addresses used in 7-bit mode keep bits [9:7] at zero. The stimulus changes the configuration only between address phases. It strobes each byte for exactly one clock. It drives `start_det` on its own, except for the one directed case that tests the collision rule.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;
   localparam int BYTE_W = 8;
   localparam int ADR_W  = 10;
   localparam logic [4:0] TEN_PREFIX = 5'b11110;

   // 1 where the received bit agrees with the address or is masked
   function automatic logic all_agree(input logic [ADR_W-1:0] rx,
                                      input logic [ADR_W-1:0] ad,
                                      input logic [ADR_W-1:0] mk);
      return &(~((rx ^ ad) & ~mk));
   endfunction
endpackage

// File: rtl/i2cam_slot_cmp.sv
module i2cam_slot_cmp
   import i2cam_pkg::*;
(
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic [ADR_W-1:0]  addr,
   input  logic [ADR_W-1:0]  mask,
   output logic              hit7,
   output logic              hi_ok,
   output logic              lo_ok
);
   // place the received bits at the address positions they face
   logic [ADR_W-1:0] rx7, rxhi, rxlo;

   always_comb begin
      rx7  = addr;
      rx7[6:0] = rx_byte[7:1];
      rxhi = addr;
      rxhi[9:8] = rx_byte[2:1];
      rxlo = addr;
      rxlo[7:0] = rx_byte;
   end

   assign hit7  = all_agree(rx7, addr, mask);
   assign hi_ok = all_agree(rxhi, addr, mask);
   assign lo_ok = all_agree(rxlo, addr, mask);
endmodule

// File: rtl/i2cam_sticky.sv
module i2cam_sticky #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr) | set;
   end
endmodule

// File: rtl/i2c_dual_addr_match.sv
module i2c_dual_addr_match
   import i2cam_pkg::*;
#(
   parameter int SLOTS = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_det,
   input  logic                   byte_vld,
   input  logic                   byte_first,
   input  logic [7:0]             byte_data,
   input  logic                   cfg_ten_bit,
   input  logic                   cfg_gc_en,
   input  logic                   cfg_ack_en,
   input  logic [SLOTS*10-1:0]    slot_addr,
   input  logic [SLOTS*10-1:0]    slot_mask,
   input  logic [SLOTS-1:0]       sts_clr,
   output logic                   match,
   output logic                   ack_req,
   output logic                   read_req,
   output logic [SLOTS-1:0]       hit_sts
);
   generate
      if (SLOTS < 1 || SLOTS > 8) begin : g_bad_slots
         $error("SLOTS must be in 1..8");
      end
   endgenerate

   logic [SLOTS-1:0] hit7, hi_ok, lo_ok, armed_q, hit_now;
   logic             rw_q;

   genvar gi;
   generate
      for (gi = 0; gi < SLOTS; gi++) begin : g_slot
         i2cam_slot_cmp u_cmp (
            .rx_byte (byte_data),
            .addr    (slot_addr[gi*ADR_W +: ADR_W]),
            .mask    (slot_mask[gi*ADR_W +: ADR_W]),
            .hit7    (hit7[gi]),
            .hi_ok   (hi_ok[gi]),
            .lo_ok   (lo_ok[gi])
         );
      end
   endgenerate

   logic first_b, next_b, zero7, is_gc, prefix_ok, gc_hit, arm_any;
   logic [SLOTS-1:0] arm_set;

   always_comb begin
      first_b   = byte_vld && byte_first && !start_det;
      next_b    = byte_vld && !byte_first && !start_det;
      zero7     = (byte_data[7:1] == 7'd0);
      is_gc     = (byte_data == 8'h00);
      prefix_ok = (byte_data[7:3] == TEN_PREFIX);
      arm_set   = (cfg_ten_bit && prefix_ok) ? hi_ok : '0;
      arm_any   = first_b && (|arm_set);
      gc_hit    = first_b && cfg_gc_en && is_gc;
      if (cfg_ten_bit) hit_now = next_b ? (armed_q & lo_ok) : '0;
      else             hit_now = (first_b && !zero7) ? hit7 : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= '0;
         rw_q    <= 1'b0;
      end else if (start_det) begin
         armed_q <= '0;
      end else if (first_b) begin
         armed_q <= arm_set;
         rw_q    <= byte_data[0];
      end else if (next_b) begin
         armed_q <= '0;
      end
   end

   logic rw_eff;
   assign rw_eff = cfg_ten_bit ? rw_q : byte_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match    <= 1'b0;
         ack_req  <= 1'b0;
         read_req <= 1'b0;
      end else begin
         match    <= (|hit_now) || gc_hit;
         ack_req  <= cfg_ack_en && ((|hit_now) || gc_hit || arm_any);
         read_req <= (|hit_now) && rw_eff;
      end
   end

   i2cam_sticky #(.W(SLOTS)) u_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (hit_now),
      .clr   (sts_clr),
      .q     (hit_sts)
   );
endmodule

// File: rtl/i2c_dual_addr_match_chk.sv
module i2c_dual_addr_match_chk #(
   parameter int SLOTS = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_det,
   input logic             byte_vld,
   input logic             cfg_ack_en,
   input logic [SLOTS-1:0] sts_clr,
   input logic             match,
   input logic             ack_req,
   input logic             read_req,
   input logic [SLOTS-1:0] hit_sts
);
   assert_match_needs_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |=> !match);

   assert_start_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !match && !ack_req);

   assert_read_with_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
      read_req |-> match);

   assert_no_ack_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ack_en |=> !ack_req);

   genvar gi;
   generate
      for (gi = 0; gi < SLOTS; gi++) begin : g_chk
         assert_sts_rise_on_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hit_sts[gi]) |-> match);
         assert_sts_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            sts_clr[gi] |=> !hit_sts[gi] || match);
      end
   endgenerate
endmodule

bind i2c_dual_addr_match i2c_dual_addr_match_chk #(.SLOTS(SLOTS)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_det(start_det), .byte_vld(byte_vld),
   .cfg_ack_en(cfg_ack_en), .sts_clr(sts_clr), .match(match),
   .ack_req(ack_req), .read_req(read_req), .hit_sts(hit_sts));

// File: tb/i2c_dual_addr_match_test.sv
module i2c_dual_addr_match_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_det = 0, byte_vld = 0, byte_first = 0;
   logic [7:0] byte_data = '0;
   logic cfg_ten_bit = 0, cfg_gc_en = 0, cfg_ack_en = 1;
   logic [19:0] slot_addr = '0, slot_mask = '0;
   logic [1:0] sts_clr = '0;
   logic match, ack_req, read_req;
   logic [1:0] hit_sts;
   int total = 0, bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   i2c_dual_addr_match uut (
      .clk(clk), .rst_n(rst_n), .start_det(start_det), .byte_vld(byte_vld),
      .byte_first(byte_first), .byte_data(byte_data), .cfg_ten_bit(cfg_ten_bit),
      .cfg_gc_en(cfg_gc_en), .cfg_ack_en(cfg_ack_en), .slot_addr(slot_addr),
      .slot_mask(slot_mask), .sts_clr(sts_clr), .match(match), .ack_req(ack_req),
      .read_req(read_req), .hit_sts(hit_sts));

   // {byte, gc_en, ack_en, exp match, exp ack, exp read, exp sts[1:0], 0}
   localparam logic [15:0] VEC [9] = '{
      {8'hA0, 8'b01110110}, {8'hA5, 8'b01111100}, {8'hA2, 8'b01000000},
      {8'hA4, 8'b01110100}, {8'h00, 8'b11110000}, {8'h00, 8'b01000000},
      {8'h01, 8'b11000000}, {8'hA0, 8'b00100110}, {8'hA1, 8'b00101110}};

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b, input logic first, input logic st,
                       input logic [1:0] clr);
      @(negedge clk);
      byte_vld = 1; byte_first = first; byte_data = b; start_det = st; sts_clr = clr;
      @(negedge clk);
      byte_vld = 0; byte_first = 0; start_det = 0; sts_clr = 0;
   endtask

   task automatic pulse_start();
      @(negedge clk); start_det = 1;
      @(negedge clk); start_det = 0;
   endtask

   task automatic clear_all(input string req);
      @(negedge clk); sts_clr = 2'b11;
      @(negedge clk); sts_clr = 0;
      chk(req, {6'd0, hit_sts}, 8'h00);
   endtask

   task automatic expect3(input string req, input logic m, input logic a, input logic r,
                          input logic [1:0] s);
      chk(req, {5'd0, match, ack_req, read_req}, {5'd0, m, a, r});
      chk(req, {6'd0, hit_sts}, {6'd0, s});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      expect3("R1", 0, 0, 0, 2'b00);
      rst_n = 1;
      @(negedge clk);
      expect3("R1", 0, 0, 0, 2'b00);

      // 7-bit table: slot0 0x050 exact, slot1 0x052 with bit 1 don't-care
      slot_addr = {10'h052, 10'h050};
      slot_mask = {10'h002, 10'h000};
      for (int i = 0; i < 9; i++) begin
         cfg_gc_en  = VEC[i][7];
         cfg_ack_en = VEC[i][6];
         pulse_start();
         send(VEC[i][15:8], 1, 0, 2'b00);
         expect3($sformatf("R2/R3/R7/R8/R9 vector %0d", i),
                 VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2:1]);
         clear_all("R7 clear");
      end

      // 10-bit mode
      cfg_ten_bit = 1; cfg_gc_en = 0; cfg_ack_en = 1;
      slot_addr = {10'h1A5, 10'h2A5};
      slot_mask = '0;
      pulse_start();
      send(8'hF4, 1, 0, 0);
      expect3("R4 first byte arms slot0", 0, 1, 0, 2'b00);
      send(8'hA5, 0, 0, 0);
      expect3("R5 second byte hits slot0", 1, 1, 0, 2'b01);
      clear_all("R7 clear");

      pulse_start();
      send(8'hF1, 1, 0, 0);
      expect3("R4 no slot agrees", 0, 0, 0, 2'b00);
      send(8'hA5, 0, 0, 0);
      expect3("R10 unarmed byte ignored", 0, 0, 0, 2'b00);

      pulse_start();
      send(8'hF2, 1, 1, 0);
      expect3("R6 byte with start ignored", 0, 0, 0, 2'b00);
      send(8'hF2, 1, 0, 0);
      expect3("R4 slot1 armed", 0, 1, 0, 2'b00);
      pulse_start();
      send(8'hA5, 0, 0, 0);
      expect3("R6 start disarms", 0, 0, 0, 2'b00);

      pulse_start();
      send(8'hF3, 1, 0, 0);
      send(8'hA5, 0, 0, 0);
      expect3("R8 ten-bit read", 1, 1, 1, 2'b10);
      clear_all("R7 clear");

      cfg_ack_en = 0;
      pulse_start();
      send(8'hF4, 1, 0, 0);
      expect3("R9 first byte no ack", 0, 0, 0, 2'b00);
      send(8'hA5, 0, 0, 0);
      expect3("R9 match without ack", 1, 0, 0, 2'b01);
      clear_all("R7 clear");
      cfg_ack_en = 1;

      // upper bits masked on slot1
      slot_mask = {10'h300, 10'h000};
      pulse_start();
      send(8'hF0, 1, 0, 0);
      send(8'hA5, 0, 0, 0);
      expect3("R4 masked upper bits", 1, 1, 0, 2'b10);
      clear_all("R7 clear");

      // both slots hit, partial clear, set wins over clear
      slot_addr = {10'h2A5, 10'h2A5};
      slot_mask = '0;
      pulse_start();
      send(8'hF4, 1, 0, 0);
      send(8'hA5, 0, 0, 0);
      expect3("R7 both slots", 1, 1, 0, 2'b11);
      @(negedge clk); sts_clr = 2'b01;
      @(negedge clk); sts_clr = 0;
      chk("R7 partial clear", {6'd0, hit_sts}, 8'h02);
      pulse_start();
      send(8'hF4, 1, 0, 0);
      send(8'hA5, 0, 0, 2'b11);
      expect3("R7 set wins over clear", 1, 1, 0, 2'b11);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule